// File: doc/BRIEF.md
# ALU Status Flag Register Unit

This block holds an 8-bit processor status byte and works out its arithmetic flags from the operation the datapath is running. Each cycle it takes an operation code, two byte operands, a flag that says whether the instruction treats its operands as bytes, and the current accumulator contents. From these it forms the ALU result and, when the operation is enabled, updates carry, auxiliary carry and overflow in the stored byte on the next rising clock edge.

The parity bit follows the accumulator on every clock edge, whether or not an operation runs. Two bank-select bits in the status byte pick one of four eight-entry register banks, and the block outputs the base address of the selected bank. Software can overwrite the whole status byte in one cycle, except the parity bit. Two general-purpose bits are kept for software and no operation changes them.

Status byte layout, from bit 7 down to bit 0: carry (CY), auxiliary carry (AC), user flag A, bank select high, bank select low, overflow (OV), user flag B, parity (P).

Top module: `sfr_flag_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `status_q` becomes 0x00, whatever `sw_we` and `acc_value` are.
- R2: Add (code 0) and add-with-carry (code 1) give `result_lo` = low byte of A + B + cin, where cin is the stored CY for code 1 and 0 for code 0. When `op_en` is high they set CY to the carry out of bit 7.
- R3: Subtract (code 2), subtract-with-borrow (code 3) and compare (code 4) form A − B − bin, where bin is the stored CY for code 3 and 0 otherwise. When `op_en` is high they set CY to 1 exactly when bit 7 needs a borrow.
- R4: When `size_byte` is 1, codes 0 to 4 set AC to the carry out of bit 3 (add) or the borrow into bit 3 (subtract and compare), and clear it otherwise.
- R5: When `size_byte` is 0, and for codes 5, 6 and 7, AC is left unchanged.
- R6: Codes 0 to 4 set OV to 1 exactly when the signed two's-complement result falls outside −128..127.
- R7: Multiply (code 5) gives the product low byte on `result_lo` and the high byte on `result_hi`. It clears CY and sets OV to 1 exactly when the high byte is non-zero.
- R8: Divide (code 6) gives the quotient on `result_lo` and the remainder on `result_hi`, and clears CY and OV. A zero divisor gives 0 on both outputs, sets OV and clears CY.
- R9: `result_write` is 0 for compare and 1 for every other code. Pass (code 7) puts B on `result_lo` and changes no flag. `result_hi` is 0 for codes 0 to 4 and 7.
- R10: On every rising edge out of reset, P becomes the XOR of the eight `acc_value` bits.
- R11: `bank_base` equals 8 × {bit 4, bit 3} of `status_q`, giving 0x00, 0x08, 0x10 or 0x18.
- R12: When `sw_we` is high, bits 7..1 take `sw_data[7:1]` even if an operation is enabled in the same cycle, while P still follows R10. Bits 5 and 1 change only through this write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_en | input | 1 | Lets the current operation update the flags |
| op_code | input | 3 | Operation select, codes 0 to 7 |
| operand_a | input | 8 | First operand, dividend |
| operand_b | input | 8 | Second operand, divisor |
| size_byte | input | 1 | 1 when the instruction works on byte operands |
| acc_value | input | 8 | Current accumulator contents |
| sw_we | input | 1 | Software write strobe for the status byte |
| sw_data | input | 8 | Software write data, bit 0 ignored |
| result_lo | output | 8 | Result, product low byte or quotient |
| result_hi | output | 8 | Product high byte or remainder |
| result_write | output | 1 | 1 when the result goes back to the accumulator |
| status_q | output | 8 | Stored status byte |
| bank_base | output | 5 | Base address of the active register bank |

## Verification
The bench aims at the chained carry cases: add-with-carry and subtract-with-borrow that read a stale or freshly written CY, where a design that mixes up the order would be off by one. It checks nibble carry and borrow at 0x0F+0x01 and 0x10−0x01, and it checks that AC holds on wide operations, where a design that always updates AC would clear it. It also covers signed overflow at 0x7F+1 and 0x80−1, a multiply whose result is exactly 0x100, and a divide by zero, where an unguarded design would leave OV clear or put garbage on the outputs. A software write made in the same cycle as a flag-setting operation must win, and a design that lets the write reach P would break parity tracking.

// File: rtl/sfr_pkg.sv
// Package: shared widths, status-byte bit positions and operation codes
// for the status flag unit. Assumes an 8-bit data path and four banks.
package sfr_pkg;

    localparam int DATA_W      = 8;
    localparam int NUM_BANKS   = 4;
    localparam int BANK_REGS   = 8;
    localparam int BANK_ADDR_W = $clog2(NUM_BANKS * BANK_REGS);
    localparam int BANK_SEL_W  = $clog2(NUM_BANKS);

    // Bit positions inside the status byte; other logic decodes these.
    localparam int BIT_CY  = 7;
    localparam int BIT_AC  = 6;
    localparam int BIT_UA  = 5;
    localparam int BIT_RSH = 4;
    localparam int BIT_RSL = 3;
    localparam int BIT_OV  = 2;
    localparam int BIT_UB  = 1;
    localparam int BIT_P   = 0;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBB = 3'd3,
        OP_CMP  = 3'd4,
        OP_MUL  = 3'd5,
        OP_DIV  = 3'd6,
        OP_PASS = 3'd7
    } alu_op_e;

    // Write enables and new values for the hardware-owned flags.
    typedef struct packed {
        logic cy_we;
        logic cy;
        logic ac_we;
        logic ac;
        logic ov_we;
        logic ov;
    } flag_upd_t;

endpackage

// File: rtl/sfr_alu_core.sv
// Module: sfr_alu_core
// Combinational arithmetic for the status unit. It forms the result bytes,
// the write-back flag and the flag update for the selected operation.
// Assumes W is even; the half-width carry is taken at bit W/2-1.
module sfr_alu_core
    import sfr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           size_byte,
    input  logic           cy_in,
    output logic [W-1:0]   res_lo,
    output logic [W-1:0]   res_hi,
    output logic           wr_back,
    output flag_upd_t      upd
);

    localparam int HALF = W / 2;

    logic           chain_in;
    logic [W:0]     sum_full;
    logic [W:0]     dif_full;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo;
    logic [W-1:0]   rem;
    logic           half_cy_add;
    logic           half_cy_sub;
    logic           ov_add;
    logic           ov_sub;

    // Carry or borrow input: the stored CY for the chained variants only.
    always_comb begin
        chain_in = ((op == OP_ADDC) || (op == OP_SUBB)) ? cy_in : 1'b0;
    end

    // Wide add, subtract and multiply with all carries kept.
    always_comb begin
        sum_full = {1'b0, a} + {1'b0, b} + (W+1)'(chain_in);
        dif_full = {1'b0, a} - {1'b0, b} - (W+1)'(chain_in);
        prod     = (2*W)'(a) * (2*W)'(b);
    end

    // Divide, with the zero-divisor case pinned to zero outputs.
    always_comb begin
        if (b == '0) begin
            quo = '0;
            rem = '0;
        end else begin
            quo = a / b;
            rem = a % b;
        end
    end

    // Half carry from the bit above the nibble boundary; signed overflow.
    always_comb begin
        half_cy_add = sum_full[HALF] ^ a[HALF] ^ b[HALF];
        half_cy_sub = dif_full[HALF] ^ a[HALF] ^ b[HALF];
        ov_add      = (a[W-1] == b[W-1]) && (sum_full[W-1] != a[W-1]);
        ov_sub      = (a[W-1] != b[W-1]) && (dif_full[W-1] != a[W-1]);
    end

    // Result and flag-update selection per operation.
    always_comb begin
        res_lo  = '0;
        res_hi  = '0;
        wr_back = 1'b1;
        upd     = '0;
        unique case (op)
            OP_ADD, OP_ADDC: begin
                res_lo    = sum_full[W-1:0];
                upd.cy_we = 1'b1;
                upd.cy    = sum_full[W];
                upd.ac_we = size_byte;
                upd.ac    = half_cy_add;
                upd.ov_we = 1'b1;
                upd.ov    = ov_add;
            end
            OP_SUB, OP_SUBB, OP_CMP: begin
                res_lo    = dif_full[W-1:0];
                wr_back   = (op != OP_CMP);
                upd.cy_we = 1'b1;
                upd.cy    = dif_full[W];
                upd.ac_we = size_byte;
                upd.ac    = half_cy_sub;
                upd.ov_we = 1'b1;
                upd.ov    = ov_sub;
            end
            OP_MUL: begin
                res_lo    = prod[W-1:0];
                res_hi    = prod[2*W-1:W];
                upd.cy_we = 1'b1;
                upd.cy    = 1'b0;
                upd.ov_we = 1'b1;
                upd.ov    = (prod[2*W-1:W] != '0);
            end
            OP_DIV: begin
                res_lo    = quo;
                res_hi    = rem;
                upd.cy_we = 1'b1;
                upd.cy    = 1'b0;
                upd.ov_we = 1'b1;
                upd.ov    = (b == '0);
            end
            default: begin
                res_lo = b;
            end
        endcase
    end

endmodule

// File: rtl/sfr_parity.sv
// Module: sfr_parity
// Odd-parity reduction of the accumulator: 1 when an odd number of bits
// are set. Purely combinational; the caller registers it.
module sfr_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    output logic         odd
);

    // XOR-fold every bit of the value.
    always_comb begin
        odd = 1'b0;
        for (int i = 0; i < W; i++) begin
            odd = odd ^ value[i];
        end
    end

endmodule

// File: rtl/sfr_bank_decode.sv
// Module: sfr_bank_decode
// Turns the bank-select field into the base address of the active bank.
// Assumes BANK_REGS is a power of two so the base is a plain shift.
module sfr_bank_decode #(
    parameter int SEL_W     = 2,
    parameter int BANK_REGS = 8,
    parameter int ADDR_W    = 5
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] base
);

    localparam int SHIFT = $clog2(BANK_REGS);

    // Base address = bank number times bank size.
    always_comb begin
        base = ADDR_W'(sel) << SHIFT;
    end

endmodule

// File: rtl/sfr_status_reg.sv
// Module: sfr_status_reg
// Holds the status byte. Software writes win over hardware flag updates;
// parity is reloaded every cycle and cannot be written by software.
// Assumes a synchronous active-low reset.
module sfr_status_reg
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  flag_upd_t         upd,
    input  logic              parity,
    input  logic              sw_we,
    input  logic [DATA_W-1:0] sw_data,
    output logic [DATA_W-1:0] q
);

    // Status byte update: reset, then software write, then hardware flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (sw_we) begin
                q <= {sw_data[DATA_W-1:1], parity};
            end else begin
                q[BIT_P] <= parity;
                if (upd_en && upd.cy_we) q[BIT_CY] <= upd.cy;
                if (upd_en && upd.ac_we) q[BIT_AC] <= upd.ac;
                if (upd_en && upd.ov_we) q[BIT_OV] <= upd.ov;
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (q == '0)); // R1

    AST_USER_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> (q[BIT_UA] == $past(q[BIT_UA])) && (q[BIT_UB] == $past(q[BIT_UB]))); // R12

    AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (q[DATA_W-1:1] == $past(sw_data[DATA_W-1:1]))); // R12

endmodule

// File: rtl/sfr_flag_unit.sv
// Module: sfr_flag_unit (top)
// Status flag unit: ALU result and flag computation, the stored status
// byte, accumulator parity tracking and register-bank base decode.
// Assumes the caller applies result_lo/result_hi to the accumulator.
module sfr_flag_unit
    import sfr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_en,
    input  logic [2:0]             op_code,
    input  logic [DATA_W-1:0]      operand_a,
    input  logic [DATA_W-1:0]      operand_b,
    input  logic                   size_byte,
    input  logic [DATA_W-1:0]      acc_value,
    input  logic                   sw_we,
    input  logic [DATA_W-1:0]      sw_data,
    output logic [DATA_W-1:0]      result_lo,
    output logic [DATA_W-1:0]      result_hi,
    output logic                   result_write,
    output logic [DATA_W-1:0]      status_q,
    output logic [BANK_ADDR_W-1:0] bank_base
);

    alu_op_e   op;
    flag_upd_t upd;
    logic      acc_odd;

    // Decode the raw code into the operation type.
    always_comb begin
        op = alu_op_e'(op_code);
    end

    sfr_alu_core #(.W(DATA_W)) u_core (
        .op        (op),
        .a         (operand_a),
        .b         (operand_b),
        .size_byte (size_byte),
        .cy_in     (status_q[BIT_CY]),
        .res_lo    (result_lo),
        .res_hi    (result_hi),
        .wr_back   (result_write),
        .upd       (upd)
    );

    sfr_parity #(.W(DATA_W)) u_parity (
        .value (acc_value),
        .odd   (acc_odd)
    );

    sfr_status_reg u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (op_en),
        .upd     (upd),
        .parity  (acc_odd),
        .sw_we   (sw_we),
        .sw_data (sw_data),
        .q       (status_q)
    );

    sfr_bank_decode #(
        .SEL_W     (BANK_SEL_W),
        .BANK_REGS (BANK_REGS),
        .ADDR_W    (BANK_ADDR_W)
    ) u_bank (
        .sel  (status_q[BIT_RSH:BIT_RSL]),
        .base (bank_base)
    );

    AST_MULDIV_CY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && !sw_we && (op_code == 3'd5 || op_code == 3'd6)) |=> !status_q[BIT_CY]); // R7

    AST_DIV_ZERO_OV: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && !sw_we && op_code == 3'd6 && operand_b == '0) |=> status_q[BIT_OV]); // R8

    AST_WIDE_AC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && !sw_we && !size_byte) |=> (status_q[BIT_AC] == $past(status_q[BIT_AC]))); // R5

    AST_PARITY_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_q[BIT_P] == ^$past(acc_value))); // R10

    AST_BANK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bank_base[2:0] == 3'b000); // R11

endmodule

// File: tb/tb_sfr_flag_unit.sv
`timescale 1ns/1ps
module tb_sfr_flag_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_en = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [7:0] operand_a = 8'h00;
    logic [7:0] operand_b = 8'h00;
    logic       size_byte = 1'b1;
    logic [7:0] acc_value = 8'h00;
    logic       sw_we = 1'b0;
    logic [7:0] sw_data = 8'h00;
    logic [7:0] result_lo;
    logic [7:0] result_hi;
    logic       result_write;
    logic [7:0] status_q;
    logic [4:0] bank_base;

    int checks = 0;
    int failures = 0;
    int model = 0;   // expected status byte
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sfr_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
        .operand_a(operand_a), .operand_b(operand_b), .size_byte(size_byte),
        .acc_value(acc_value), .sw_we(sw_we), .sw_data(sw_data),
        .result_lo(result_lo), .result_hi(result_hi), .result_write(result_write),
        .status_q(status_q), .bank_base(bank_base)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int sgn(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    function automatic int par8(input int v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += (v >> i) & 1;
        return c % 2;
    endfunction

    // One operation cycle: drive, check result outputs, then status after the edge.
    task automatic step(input string tag, input bit en, input int op, input int a,
                        input int b, input bit sz, input int acc, input bit we, input int swd);
        int lo, hi, wr, cy, ac, ov, nxt, cin, full, sa, sb, sr;
        bit upd_ac, upd_arith;
        @(negedge clk);
        op_en = en; op_code = op[2:0]; operand_a = a[7:0]; operand_b = b[7:0];
        size_byte = sz; acc_value = acc[7:0]; sw_we = we; sw_data = swd[7:0];
        #1;
        cy = (model >> 7) & 1; ac = (model >> 6) & 1; ov = (model >> 2) & 1;
        hi = 0; wr = (op != 4) ? 1 : 0; upd_ac = 0; upd_arith = 1;
        cin = (op == 1 || op == 3) ? cy : 0;
        sa = sgn(a); sb = sgn(b);
        if (op <= 1) begin
            full = a + b + cin; lo = full % 256;
            cy = (full > 255) ? 1 : 0;
            ac = (((a % 16) + (b % 16) + cin) > 15) ? 1 : 0; upd_ac = sz;
            sr = sa + sb + cin; ov = (sr > 127 || sr < -128) ? 1 : 0;
        end else if (op <= 4) begin
            full = a - b - cin; lo = (full + 256) % 256;
            cy = (full < 0) ? 1 : 0;
            ac = (((a % 16) - (b % 16) - cin) < 0) ? 1 : 0; upd_ac = sz;
            sr = sa - sb - cin; ov = (sr > 127 || sr < -128) ? 1 : 0;
        end else if (op == 5) begin
            full = a * b; lo = full % 256; hi = full / 256;
            cy = 0; ov = (full > 255) ? 1 : 0;
        end else if (op == 6) begin
            cy = 0;
            if (b == 0) begin lo = 0; hi = 0; ov = 1; end
            else begin lo = a / b; hi = a % b; ov = 0; end
        end else begin
            lo = b; upd_arith = 0;
        end
        check({tag, " result_lo"}, result_lo, lo);
        check({tag, " result_hi"}, result_hi, hi);
        check({tag, " result_write (R9)"}, result_write, wr);
        if (we) begin
            nxt = (swd & 8'hFE) | par8(acc);
        end else begin
            nxt = (model & 8'hFE) | par8(acc);
            if (en && upd_arith) begin
                nxt = (nxt & 8'h7B) | (cy << 7) | (ov << 2);
                if (upd_ac) nxt = (nxt & 8'hBF) | (ac << 6);
            end
        end
        @(posedge clk);
        #2;
        model = nxt;
        check({tag, " status"}, status_q, model);
        check("R10 parity", status_q[0], par8(acc));
        check("R11 bank_base", bank_base, ((model >> 3) & 3) * 8);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset dominates writes and accumulator parity
        acc_value = 8'hFF; sw_we = 1'b1; sw_data = 8'hFF;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset status", status_q, 8'h00);
        check("R1 reset bank", bank_base, 0);
        @(negedge clk);
        rst_n = 1'b1; sw_we = 1'b0; acc_value = 8'h00;
        model = 0;
        step("R1 idle", 0, 0, 0, 0, 1, 0, 0, 0);

        // R2 add family
        step("R2 R4 add nibble carry", 1, 0, 8'h0F, 8'h01, 1, 8'h10, 0, 0);
        step("R6 add overflow", 1, 0, 8'h7F, 8'h01, 1, 8'h80, 0, 0);
        step("R2 add carry out", 1, 0, 8'hFF, 8'h01, 1, 8'h00, 0, 0);
        step("R2 addc with cy", 1, 1, 8'h10, 8'h20, 1, 8'h31, 0, 0);
        step("R2 addc without cy", 1, 1, 8'h10, 8'h20, 1, 8'h30, 0, 0);
        // R3 subtract family
        step("R3 R4 sub nibble borrow", 1, 2, 8'h10, 8'h01, 1, 8'h0F, 0, 0);
        step("R3 sub borrow", 1, 2, 8'h00, 8'h01, 1, 8'hFF, 0, 0);
        step("R3 subb with borrow", 1, 3, 8'h50, 8'h10, 1, 8'h3F, 0, 0);
        step("R6 sub overflow", 1, 2, 8'h80, 8'h01, 1, 8'h7F, 0, 0);
        step("R3 R9 cmp", 1, 4, 8'h05, 8'h09, 1, 8'h7F, 0, 0);
        // R5 AC hold on wide operands
        step("R4 set ac", 1, 0, 8'h08, 8'h08, 1, 8'h10, 0, 0);
        step("R5 wide add keeps ac", 1, 0, 8'h01, 8'h02, 0, 8'h03, 0, 0);
        step("R5 wide sub keeps ac", 1, 2, 8'h20, 8'h01, 0, 8'h1F, 0, 0);
        // R7 multiply
        step("R7 mul overflow", 1, 5, 8'h10, 8'h10, 1, 8'h00, 0, 0);
        step("R7 mul small", 1, 5, 8'h03, 8'h04, 1, 8'h0C, 0, 0);
        step("R7 mul max", 1, 5, 8'hFF, 8'hFF, 1, 8'h01, 0, 0);
        // R8 divide
        step("R8 div", 1, 6, 8'h07, 8'h02, 1, 8'h03, 0, 0);
        step("R8 div by zero", 1, 6, 8'h2A, 8'h00, 1, 8'h00, 0, 0);
        // R9 pass keeps flags
        step("R9 pass", 1, 7, 8'h11, 8'hA5, 1, 8'hA5, 0, 0);
        // op_en low: no flag change
        step("R2 disabled add", 0, 0, 8'hFF, 8'hFF, 1, 8'h01, 0, 0);
        // R12 software write wins and cannot touch P
        step("R12 sw write all ones", 1, 0, 8'hFF, 8'h01, 1, 8'h03, 1, 8'hFF);
        step("R12 sw write zero vs op", 1, 6, 8'h01, 8'h00, 1, 8'h01, 1, 8'h00);
        step("R12 user bits after ops", 1, 2, 8'h00, 8'h01, 1, 8'h00, 0, 0);
        // R11 bank selection through software
        for (int k = 0; k < 4; k++) begin
            step("R11 bank select", 0, 0, 0, 0, 1, 0, 1, (k << 3) | 8'h22);
        end
        step("R12 user bits kept by mul", 1, 5, 8'h20, 8'h20, 1, 8'h00, 0, 0);

        // Mixed random traffic against the model
        for (int n = 0; n < 400; n++) begin
            step("random", ($urandom % 4) != 0, $urandom % 8, $urandom % 256,
                 (($urandom % 8) == 0) ? 0 : $urandom % 256, $urandom % 2,
                 $urandom % 256, ($urandom % 10) == 0, $urandom % 256);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule